// File: doc/BRIEF.md
# Ethernet receive address filter

This block sits at the head of a receive path and decides, one frame at a time, whether the frame should be kept. It looks at the 48-bit destination address, the frame length and a single error flag. A configuration word selects which address classes, short frames and damaged frames may pass. The block holds a station address and a 64-bit multicast hash table. Both are loaded by the host through a small write port.

For every frame presented with `frm_valid`, the block produces one registered result on the next clock. The result is an accept decision plus three class flags: broadcast, station match and multicast. A later stage places these flags into the frame status word. Each address byte travels least significant byte first: byte 0 is the first byte on the wire and occupies `frm_dst[7:0]`.

Top module: `rx_addr_filter`

## Requirements
- R1: After a synchronous reset, all result outputs are 0, the station address is all zeros and every multicast table bit is clear.
- R2: A host write with `reg_wr_sel` 0 loads address bytes 3..0 from `reg_wr_data[31:0]` (byte 0 in bits 7:0). Select 1 loads bytes 5..4 from bits 15:0. Select 2 loads table bits 31:0 and select 3 loads table bits 63:32.
- R3: The address class is decided in this order. Broadcast means all 48 bits are set. Multicast means bit 0 of byte 0 is set and the address is not broadcast. Station match means a unicast address equal to the stored station address. At most one of `res_bcast`, `res_phys` and `res_mcast` is set. These flags report the class whether or not the frame is accepted, and they are 0 when `res_valid` is 0.
- R4: Configuration bit 1 accepts a station-match frame.
- R5: Configuration bit 2 accepts a multicast frame only if a particular table bit is set. That bit is indexed by the upper 6 bits of a CRC-32 over the address, computed as follows: polynomial 0x04C11DB7, register preset to all ones, no final inversion, and address bits fed in from `frm_dst[0]` upward.
- R6: Configuration bit 3 accepts a broadcast frame.
- R7: Configuration bit 0 accepts any address, including unicast addresses that do not match. It does not lift the runt or error rules.
- R8: A frame shorter than 64 bytes is rejected unless configuration bit 4 is set. A 64-byte frame is not a runt.
- R9: A frame with `frm_err` set is rejected unless configuration bit 5 is set, or configuration bit 16 is set and the length is greater than 8.
- R10: `res_valid` is asserted exactly one cycle after each cycle with `frm_valid`. Back-to-back frames yield back-to-back results, and `res_accept` is 0 whenever `res_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Host register write strobe |
| reg_wr_sel | input | 2 | Register select: 0/1 station address, 2/3 hash table words |
| reg_wr_data | input | 32 | Host write data |
| cfg_word | input | 32 | Receive configuration word |
| frm_valid | input | 1 | Destination address, length and error flag are valid |
| frm_dst | input | 48 | Destination address, byte 0 in bits 7:0 |
| frm_len | input | 16 | Frame length in bytes |
| frm_err | input | 1 | Frame carries a receive error |
| res_valid | output | 1 | Result valid |
| res_accept | output | 1 | Frame accepted |
| res_bcast | output | 1 | Broadcast address received |
| res_phys | output | 1 | Station address matched |
| res_mcast | output | 1 | Multicast address received |

## Verification
The assertions take two things for granted. First, `cfg_word` and the stored registers stay still during the cycle a frame is sampled; the one-cycle checks relate the frame inputs to the result that follows. Second, host writes and frames may share a cycle, but a frame then sees the table contents from before the write. The stimulus changes configuration only together with a new frame, and it finishes every register write before sending the frames that depend on it, so each expected value depends only on state that has settled.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  // Configuration word enable bit positions
  localparam int CFG_ALL   = 0;
  localparam int CFG_PHYS  = 1;
  localparam int CFG_MCAST = 2;
  localparam int CFG_BCAST = 3;
  localparam int CFG_RUNT  = 4;
  localparam int CFG_ERR   = 5;
  localparam int CFG_ERR8  = 16;

  localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;

  typedef struct packed {
    logic bcast;
    logic phys;
    logic mcast;
  } addr_class_t;
endpackage

// File: rtl/rxf_regfile.sv
module rxf_regfile
  import rxf_pkg::*;
#(
  parameter int ADDR_W    = 48,
  parameter int HASH_BITS = 64,
  parameter int SEL_W     = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [SEL_W-1:0]     wr_sel,
  input  logic [31:0]          wr_data,
  output logic [ADDR_W-1:0]    station,
  output logic [HASH_BITS-1:0] hash_tbl
);
  localparam int HASH_WORDS = HASH_BITS / 32;
  localparam int HI_W       = ADDR_W - 32;

  logic [31:0]   sta_lo_q;
  logic [HI_W-1:0] sta_hi_q;
  logic [31:0]   hash_w_q [HASH_WORDS];

  always_ff @(posedge clk) begin
    if (rst) begin
      sta_lo_q <= '0;
      sta_hi_q <= '0;
    end else if (wr_en) begin
      if (wr_sel == SEL_W'(0)) sta_lo_q <= wr_data;
      if (wr_sel == SEL_W'(1)) sta_hi_q <= wr_data[HI_W-1:0];
    end
  end

  for (genvar w = 0; w < HASH_WORDS; w++) begin : g_hash_word
    always_ff @(posedge clk) begin
      if (rst) hash_w_q[w] <= '0;
      else if (wr_en && wr_sel == SEL_W'(2 + w)) hash_w_q[w] <= wr_data;
    end
    assign hash_tbl[w*32 +: 32] = hash_w_q[w];
  end

  assign station = {sta_hi_q, sta_lo_q};

  p_sta_lo_write_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == SEL_W'(0)) |=> (station[31:0] == $past(wr_data)));

  p_sta_hi_write_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == SEL_W'(1)) |=> (station[ADDR_W-1:32] == $past(wr_data[HI_W-1:0])));

  p_no_write_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(station) && $stable(hash_tbl)));
endmodule

// File: rtl/rxf_hash_index.sv
module rxf_hash_index
  import rxf_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int IDX_W  = 6
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx
);
  logic [31:0] crc;

  always_comb begin
    logic fb;
    crc = '1;
    for (int i = 0; i < ADDR_W; i++) begin
      fb  = crc[31] ^ addr[i];
      crc = {crc[30:0], 1'b0};
      if (fb) crc = crc ^ CRC_POLY;
    end
  end

  assign idx = crc[31 -: IDX_W];
endmodule

// File: rtl/rxf_decide.sv
module rxf_decide
  import rxf_pkg::*;
#(
  parameter int ADDR_W  = 48,
  parameter int LEN_W   = 16,
  parameter int MIN_LEN = 64,
  parameter int ERR_MIN = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              i_valid,
  input  logic [ADDR_W-1:0] i_dst,
  input  logic [LEN_W-1:0]  i_len,
  input  logic              i_err,
  input  logic [6:0]        i_en,      // {err8, err, runt, bcast, mcast, phys, all}
  input  logic [ADDR_W-1:0] i_station,
  input  logic              i_hash_hit,
  output logic              o_valid,
  output logic              o_accept,
  output addr_class_t       o_class
);
  localparam int E_ALL = 0, E_PHYS = 1, E_MCAST = 2, E_BCAST = 3,
                 E_RUNT = 4, E_ERR = 5, E_ERR8 = 6;

  addr_class_t cls_c;
  logic        is_bcast, is_group, addr_ok, runt, runt_ok, err_ok, acc_c;

  always_comb begin
    is_bcast    = &i_dst;
    is_group    = i_dst[0];
    cls_c.bcast = is_bcast;
    cls_c.mcast = is_group && !is_bcast;
    cls_c.phys  = !is_group && (i_dst == i_station);

    addr_ok = i_en[E_ALL]
            | (i_en[E_PHYS]  & cls_c.phys)
            | (i_en[E_MCAST] & cls_c.mcast & i_hash_hit)
            | (i_en[E_BCAST] & cls_c.bcast);

    runt    = i_len < LEN_W'(MIN_LEN);
    runt_ok = !runt || i_en[E_RUNT];
    err_ok  = !i_err || i_en[E_ERR] || (i_en[E_ERR8] && (i_len > LEN_W'(ERR_MIN)));
    acc_c   = addr_ok && runt_ok && err_ok;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      o_valid  <= 1'b0;
      o_accept <= 1'b0;
      o_class  <= '0;
    end else begin
      o_valid  <= i_valid;
      o_accept <= i_valid && acc_c;
      o_class  <= i_valid ? cls_c : '0;
    end
  end

  p_result_follows_r10: assert property (@(posedge clk) disable iff (rst)
    i_valid |=> o_valid);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !i_valid |=> (!o_valid && !o_accept && o_class == '0));

  p_class_onehot_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0({o_class.bcast, o_class.phys, o_class.mcast}));

  p_runt_block_r8: assert property (@(posedge clk) disable iff (rst)
    (i_valid && i_len < LEN_W'(MIN_LEN) && !i_en[E_RUNT]) |=> !o_accept);

  p_err_block_r9: assert property (@(posedge clk) disable iff (rst)
    (i_valid && i_err && !i_en[E_ERR] && !(i_en[E_ERR8] && i_len > LEN_W'(ERR_MIN)))
      |=> !o_accept);

  p_bcast_pass_r6: assert property (@(posedge clk) disable iff (rst)
    (i_valid && (&i_dst) && i_en[E_BCAST] && !i_err && i_len >= LEN_W'(MIN_LEN))
      |=> (o_accept && o_class.bcast));

  p_mcast_gate_r5: assert property (@(posedge clk) disable iff (rst)
    (i_valid && i_dst[0] && !(&i_dst) && !i_hash_hit && !i_en[E_ALL]) |=> !o_accept);
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rxf_pkg::*;
#(
  parameter int ADDR_W    = 48,
  parameter int LEN_W     = 16,
  parameter int HASH_BITS = 64,
  parameter int MIN_LEN   = 64,
  parameter int ERR_MIN   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr_en,
  input  logic [1:0]        reg_wr_sel,
  input  logic [31:0]       reg_wr_data,
  input  logic [31:0]       cfg_word,
  input  logic              frm_valid,
  input  logic [ADDR_W-1:0] frm_dst,
  input  logic [LEN_W-1:0]  frm_len,
  input  logic              frm_err,
  output logic              res_valid,
  output logic              res_accept,
  output logic              res_bcast,
  output logic              res_phys,
  output logic              res_mcast
);
  localparam int IDX_W = $clog2(HASH_BITS);

  logic [ADDR_W-1:0]    station;
  logic [HASH_BITS-1:0] hash_tbl;
  logic [IDX_W-1:0]     hash_idx;
  logic                 hash_hit;
  logic [6:0]           enables;
  logic                 cfg_unused;
  addr_class_t          cls;

  assign enables = {cfg_word[CFG_ERR8], cfg_word[CFG_ERR], cfg_word[CFG_RUNT],
                    cfg_word[CFG_BCAST], cfg_word[CFG_MCAST], cfg_word[CFG_PHYS],
                    cfg_word[CFG_ALL]};
  assign cfg_unused = ^{cfg_word[31:17], cfg_word[15:6]};

  rxf_regfile #(.ADDR_W(ADDR_W), .HASH_BITS(HASH_BITS), .SEL_W(2)) u_regs (
    .clk(clk), .rst(rst), .wr_en(reg_wr_en), .wr_sel(reg_wr_sel),
    .wr_data(reg_wr_data), .station(station), .hash_tbl(hash_tbl)
  );

  rxf_hash_index #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_hash (
    .addr(frm_dst), .idx(hash_idx)
  );

  assign hash_hit = hash_tbl[hash_idx];

  rxf_decide #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .MIN_LEN(MIN_LEN), .ERR_MIN(ERR_MIN)) u_dec (
    .clk(clk), .rst(rst), .i_valid(frm_valid), .i_dst(frm_dst), .i_len(frm_len),
    .i_err(frm_err), .i_en(enables), .i_station(station), .i_hash_hit(hash_hit),
    .o_valid(res_valid), .o_accept(res_accept), .o_class(cls)
  );

  assign res_bcast = cls.bcast;
  assign res_phys  = cls.phys;
  assign res_mcast = cls.mcast;

  p_accept_needs_valid_r10: assert property (@(posedge clk) disable iff (rst)
    res_accept |-> res_valid);
endmodule

// File: tb/tb_rx_addr_filter.sv
module tb_rx_addr_filter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr_en = 1'b0;
  logic [1:0]  reg_wr_sel = '0;
  logic [31:0] reg_wr_data = '0;
  logic [31:0] cfg_word = '0;
  logic        frm_valid = 1'b0;
  logic [47:0] frm_dst = '0;
  logic [15:0] frm_len = '0;
  logic        frm_err = 1'b0;
  logic res_valid, res_accept, res_bcast, res_phys, res_mcast;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [47:0] sh_sta  = '0;
  logic [63:0] sh_hash = '0;

  logic [3:0] exp_q [$];   // {accept, bcast, phys, mcast}
  string      tag_q [$];

  always #4 clk = ~clk;

  rx_addr_filter dut (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel),
    .reg_wr_data(reg_wr_data), .cfg_word(cfg_word), .frm_valid(frm_valid),
    .frm_dst(frm_dst), .frm_len(frm_len), .frm_err(frm_err),
    .res_valid(res_valid), .res_accept(res_accept), .res_bcast(res_bcast),
    .res_phys(res_phys), .res_mcast(res_mcast)
  );

  function automatic int crc_top6(input logic [47:0] a);
    logic [31:0] r = 32'hFFFF_FFFF;
    for (int b = 0; b < 6; b++) begin
      logic [7:0] by = a[8*b +: 8];
      for (int k = 0; k < 8; k++) begin
        logic msb = r[31];
        r = r << 1;
        if (msb != by[k]) r = r ^ 32'h04C1_1DB7;
      end
    end
    return int'(r[31:26]);
  endfunction

  function automatic logic [3:0] model(input logic [47:0] d, input logic [15:0] len,
                                       input logic err, input logic [31:0] c);
    logic bc, mc, ph, aok, rok, eok;
    bc  = (d == 48'hFFFF_FFFF_FFFF);
    mc  = d[0] && !bc;
    ph  = !d[0] && (d == sh_sta);
    aok = c[0] || (c[1] && ph) || (c[2] && mc && sh_hash[crc_top6(d)]) || (c[3] && bc);
    rok = (len >= 16'd64) || c[4];
    eok = !err || c[5] || (c[16] && len > 16'd8);
    return {aok && rok && eok, bc, ph, mc};
  endfunction

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic host_wr(input logic [1:0] sel, input logic [31:0] data);
    reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_data = data;
    case (sel)
      2'd0: sh_sta[31:0]   = data;
      2'd1: sh_sta[47:32]  = data[15:0];
      2'd2: sh_hash[31:0]  = data;
      default: sh_hash[63:32] = data;
    endcase
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic send(input string tag, input logic [47:0] d, input logic [15:0] len,
                      input logic err, input logic [31:0] c);
    cfg_word = c; frm_dst = d; frm_len = len; frm_err = err; frm_valid = 1'b1;
    exp_q.push_back(model(d, len, err, c));
    tag_q.push_back(tag);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    frm_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // Monitor / scoreboard
  always @(posedge clk) begin
    #2;
    if (!rst && !done) begin
      if (res_valid) begin
        if (exp_q.size() == 0) begin
          check("R10 unexpected result", {res_accept, res_bcast, res_phys, res_mcast}, 4'bxxxx);
        end else begin
          check(tag_q.pop_front(), {res_accept, res_bcast, res_phys, res_mcast}, exp_q.pop_front());
        end
      end else if (res_accept || res_bcast || res_phys || res_mcast) begin
        check("R3 flags while idle", {res_accept, res_bcast, res_phys, res_mcast}, 4'b0000);
      end
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [47:0] ma, mb, sta, other;
    int ia;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 reset outputs", {res_valid, res_accept, res_bcast, res_phys, res_mcast} [3:0],
          4'b0000);
    n_checks++;
    if (res_valid !== 1'b0) begin n_fail++; $display("FAIL R1: valid got %b expected 0", res_valid); end

    // R1: reset station is zero, table empty
    send("R1 zero station match", 48'h0, 16'd64, 1'b0, 32'h2);
    ma = 48'h0000_0000_3301;
    send("R1 empty hash table", ma, 16'd64, 1'b0, 32'h4);
    idle(2);

    // R2: load station, least significant byte first
    sta = 48'h5E4D_3C2B_1A02;
    host_wr(2'd0, 32'h3C2B_1A02);
    host_wr(2'd1, 32'hFFFF_5E4D);
    send("R2 R4 station match accepted", sta, 16'd100, 1'b0, 32'h2);
    send("R4 station match without enable", sta, 16'd100, 1'b0, 32'h0);
    other = 48'h5E4D_3C2B_1A04;
    send("R4 other unicast rejected", other, 16'd100, 1'b0, 32'h2);
    send("R2 old zero station no longer matches", 48'h0, 16'd100, 1'b0, 32'h2);

    // R6 broadcast
    send("R6 broadcast accepted", 48'hFFFF_FFFF_FFFF, 16'd64, 1'b0, 32'h8);
    send("R6 broadcast without enable", 48'hFFFF_FFFF_FFFF, 16'd64, 1'b0, 32'h6);
    idle(1);

    // R5 multicast hash
    ia = crc_top6(ma);
    mb = ma;
    while (crc_top6(mb) == ia) mb = mb + 48'h100;
    if (ia < 32) host_wr(2'd2, 32'h1 << ia);
    else         host_wr(2'd3, 32'h1 << (ia - 32));
    send("R5 multicast hash hit", ma, 16'd80, 1'b0, 32'h4);
    send("R5 multicast hash miss", mb, 16'd80, 1'b0, 32'h4);
    send("R5 multicast enable off", ma, 16'd80, 1'b0, 32'h2);

    // R7 accept all
    send("R7 accept-all unicast", other, 16'd200, 1'b0, 32'h1);
    send("R7 accept-all multicast miss", mb, 16'd200, 1'b0, 32'h1);
    send("R7 R8 accept-all runt", other, 16'd20, 1'b0, 32'h1);
    idle(1);

    // R8 runts
    send("R8 runt rejected", sta, 16'd60, 1'b0, 32'h2);
    send("R8 runt allowed", sta, 16'd60, 1'b0, 32'h12);
    send("R8 63 bytes rejected", sta, 16'd63, 1'b0, 32'h2);
    send("R8 64 bytes accepted", sta, 16'd64, 1'b0, 32'h2);

    // R9 errors
    send("R9 error rejected", sta, 16'd100, 1'b1, 32'h2);
    send("R9 error allowed", sta, 16'd100, 1'b1, 32'h22);
    send("R9 long error allowed by bit16", sta, 16'd100, 1'b1, 32'h0001_0002);
    send("R9 8-byte error rejected by bit16", sta, 16'd8, 1'b1, 32'h0001_0012);
    send("R9 9-byte error accepted by bit16", sta, 16'd9, 1'b1, 32'h0001_0012);
    idle(1);

    // R10 gaps between frames
    send("R10 isolated frame", 48'hFFFF_FFFF_FFFF, 16'd64, 1'b0, 32'h8);
    idle(3);
    send("R10 after gap", sta, 16'd64, 1'b0, 32'h2);
    idle(3);

    n_checks++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R10: got %0d pending results expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule